// File: doc/BRIEF.md
# Streaming-Programmable Sine Tone Generator

The block makes a sampled sine wave by direct digital synthesis. A phase accumulator adds a step to itself on every enabled clock. The top bits of the phase select an entry of a sine table, and that entry becomes the output sample. The output frequency is the clock frequency times the step divided by 2^PHASE_W. With a 100 MHz clock and the default 16-bit phase, a step of 0x1000 gives a 6.25 MHz tone.

The step is loaded from a valid/data input stream. A new step can arrive on any clock, so the tone can be swept in frequency one sample at a time. When no new step is offered, the last one stays in force. Samples leave on a valid/data output pair as 16-bit two's complement values, one per enabled clock. A clock enable stalls the whole pipeline. An active-low asynchronous reset clears the pipeline.

Top module: `dds_tone_gen`

## Requirements
- R1: While rst_ni is low, smp_valid_o is 0 and smp_data_o is 0. Reset clears the phase and the stored step to zero.
- R2: The phase advances by the step modulo 2^16 on every enabled clock, including across a wrap. A constant step S gives a sine period of 65536/S samples; S = 0x1000 gives a period of 16 samples.
- R3: Each valid sample equals round(32767 * sin(2*pi*a/1024)), within one LSB, where a is phase bits [15:6]. Samples are two's complement and never take the value -32768.
- R4: On an enabled clock with inc_valid_i high, inc_data_i becomes the step used for that clock's phase update, and it is stored.
- R5: On an enabled clock with inc_valid_i low, the stored step is kept and used.
- R6: While en_i is low, the phase, stored step, smp_data_o and smp_valid_o all hold their values.
- R7: A step accepted at enabled edge k first changes the sample registered at enabled edge k+1, so the latency is two registers.
- R8: After reset is released, smp_valid_o rises at the second enabled edge and stays high until the next reset.
- R9: Halving the step doubles the period: 0x0800 gives a period of 32 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for all state |
| inc_data_i | input | 16 | Phase step offered to the block |
| inc_valid_i | input | 1 | When high, inc_data_i is taken as the new step |
| smp_data_o | output | 16 | Signed sine sample |
| smp_valid_o | output | 1 | Sample is good |

## Verification
The bench builds the block with its defaults: a 16-bit phase, a 1024-entry table and 16-bit samples. Because the table index is exactly the top 10 phase bits, power-of-two steps land on exact table entries and give integer periods, so zero-crossing spacing can be counted directly for 0x1000 and 0x0800. A full-range step of 0xFFFF drives the wrap on almost every clock. Random steps, valid strobes and enable gaps reach table indices across the whole cycle.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Rounded amp*sin(2*pi*idx/2^depth_log2), computed at elaboration
  function automatic int sine_q(input int idx, input int depth_log2, input int amp);
    real pi, x, term, s, r;
    int  v;
    pi = 3.14159265358979323846;
    x  = 2.0 * pi * real'(idx) / real'(1 << depth_log2);
    if (x > pi) x = x - 2.0 * pi;
    if (x > pi / 2.0) x = pi - x;
    else if (x < -pi / 2.0) x = -pi - x;
    term = x;
    s    = x;
    for (int k = 1; k < 10; k++) begin
      term = -term * x * x / real'((2 * k) * (2 * k + 1));
      s    = s + term;
    end
    r = real'(amp) * s;
    if (r >= 0.0) v = $rtoi(r + 0.5);
    else          v = -$rtoi(-r + 0.5);
    if (v > amp)  v = amp;
    if (v < -amp) v = -amp;
    return v;
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 16,
  parameter int ADDR_W  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] inc_data_i,
  input  logic               inc_valid_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [PHASE_W-1:0] step_o,
  output logic               prime_o
);
  logic [PHASE_W-1:0] acc_q, step_q, step_eff;
  logic               prime_q;

  // a freshly offered step takes effect on the same edge
  assign step_eff = inc_valid_i ? inc_data_i : step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      step_q  <= '0;
      prime_q <= 1'b0;
    end else if (en_i) begin
      step_q  <= step_eff;
      acc_q   <= acc_q + step_eff;
      prime_q <= 1'b1;
    end
  end

  assign addr_o  = acc_q[PHASE_W-1 -: ADDR_W];
  assign step_o  = step_q;
  assign prime_o = prime_q;
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              vld_i,
  output logic [SAMP_W-1:0] data_o,
  output logic              vld_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int AMP   = (1 << (SAMP_W - 1)) - 1;

  logic [SAMP_W-1:0] rom [DEPTH];
  logic [SAMP_W-1:0] data_q;
  logic              vld_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam int VAL = dds_pkg::sine_q(i, ADDR_W, AMP);
    assign rom[i] = SAMP_W'(VAL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else if (en_i) begin
      data_q <= rom[addr_i];
      vld_q  <= vld_i;
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/dds_tone_gen.sv
module dds_tone_gen #(
  parameter int PHASE_W = 16,
  parameter int ADDR_W  = 10,
  parameter int SAMP_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] inc_data_i,
  input  logic               inc_valid_i,
  output logic [SAMP_W-1:0]  smp_data_o,
  output logic               smp_valid_o
);
  logic [ADDR_W-1:0]  addr;
  logic [PHASE_W-1:0] step_q;
  logic               prime;

  dds_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .inc_data_i (inc_data_i),
    .inc_valid_i(inc_valid_i),
    .addr_o     (addr),
    .step_o     (step_q),
    .prime_o    (prime)
  );

  dds_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_rom (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .addr_i(addr),
    .vld_i (prime),
    .data_o(smp_data_o),
    .vld_o (smp_valid_o)
  );
endmodule

// File: rtl/dds_tone_gen_chk.sv
module dds_tone_gen_chk #(
  parameter int PHASE_W = 16,
  parameter int SAMP_W  = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [PHASE_W-1:0] inc_data_i,
  input logic               inc_valid_i,
  input logic [PHASE_W-1:0] step_i,
  input logic [SAMP_W-1:0]  smp_data_i,
  input logic               smp_valid_i
);
  localparam logic [SAMP_W-1:0] NEG_FS = {1'b1, {(SAMP_W-1){1'b0}}};

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!smp_valid_i && smp_data_i == '0));

  assert_no_neg_fs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |-> smp_data_i != NEG_FS);

  assert_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && inc_valid_i) |=> step_i == $past(inc_data_i));

  assert_keep_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !inc_valid_i) |=> $stable(step_i));

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(step_i) && $stable(smp_data_i) && $stable(smp_valid_i)));

  assert_valid_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> smp_valid_i);
endmodule

bind dds_tone_gen dds_tone_gen_chk #(.PHASE_W(PHASE_W), .SAMP_W(SAMP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .inc_data_i (inc_data_i),
  .inc_valid_i(inc_valid_i),
  .step_i     (step_q),
  .smp_data_i (smp_data_o),
  .smp_valid_i(smp_valid_o)
);

// File: tb/dds_tone_gen_test.sv
module dds_tone_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] inc_d = '0;
  logic        inc_v = 1'b0;
  logic [15:0] smp;
  logic        vld;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dds_tone_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .inc_data_i(inc_d), .inc_valid_i(inc_v),
    .smp_data_o(smp), .smp_valid_o(vld)
  );

  function automatic int exp_sin(input int a);
    real r;
    r = 32767.0 * $sin(2.0 * 3.14159265358979323846 * real'(a) / 1024.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  // reference model built from the requirements
  logic [15:0] m_acc, m_step;
  int          m_smp;
  logic        m_avld, m_vld;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc <= '0; m_step <= '0; m_smp <= 0; m_avld <= 1'b0; m_vld <= 1'b0;
    end else if (en) begin
      m_smp  <= exp_sin(int'(m_acc[15:6]));
      m_vld  <= m_avld;
      m_avld <= 1'b1;
      m_step <= inc_v ? inc_d : m_step;
      m_acc  <= m_acc + (inc_v ? inc_d : m_step);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      check(vld == m_vld, "R8 valid", int'(vld), int'(m_vld));
      if (m_vld) begin
        int d;
        d = int'($signed(smp)) - m_smp;
        check(d >= -1 && d <= 1, "R3/R7 sample", int'($signed(smp)), m_smp);
        check(smp != 16'h8000, "R3 range", int'($signed(smp)), -32767);
      end
    end
  end

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; inc_v = 1'b0;
    #1;
    check(vld == 1'b0 && smp == '0, "R1 reset outputs", int'(vld), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // measure spacing of rising zero crossings with a constant step
  task automatic measure(input logic [15:0] step, input int exp_per, input string req);
    int last, n, per, prev;
    do_reset();
    @(negedge clk);
    en = 1'b1; inc_d = step; inc_v = 1'b1;
    @(negedge clk);
    inc_v = 1'b0; inc_d = $urandom; // ignored while valid low (R5)
    last = -1; n = 0; prev = 0;
    for (int i = 0; i < 8 * exp_per + 4; i++) begin
      @(negedge clk);
      if (vld) begin
        if (prev < 0 && int'($signed(smp)) >= 0) begin
          if (last >= 0) begin
            per = n - last;
            check(per == exp_per, req, per, exp_per);
          end
          last = n;
        end
        prev = int'($signed(smp));
        n++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    cmp_on = 1'b1;

    // R8: valid rises at the second enabled edge
    do_reset();
    en = 1'b1; inc_d = 16'h0040; inc_v = 1'b1;
    @(negedge clk);
    check(vld == 1'b0, "R8 first edge", int'(vld), 0);
    @(negedge clk);
    check(vld == 1'b1, "R8 second edge", int'(vld), 1);
    // R7: step 0x0040 accepted at edge 1 shows at edge 2 as index 1
    check(int'($signed(smp)) - exp_sin(1) <= 1 && exp_sin(1) - int'($signed(smp)) <= 1,
          "R7 latency", int'($signed(smp)), exp_sin(1));

    // R2/R5 and R9 periods
    measure(16'h1000, 16, "R2 period 0x1000");
    measure(16'h0800, 32, "R9 period 0x0800");

    // R2 wrap with a near-full step
    do_reset();
    en = 1'b1; inc_d = 16'hFFFF; inc_v = 1'b1;
    repeat (200) @(negedge clk);

    // R6: enable low holds outputs
    begin
      logic [15:0] hold_d;
      logic        hold_v;
      inc_d = 16'h0123;
      repeat (5) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      hold_d = smp; hold_v = vld;
      for (int i = 0; i < 10; i++) begin
        inc_d = $urandom; inc_v = $urandom;
        @(negedge clk);
        check(smp == hold_d && vld == hold_v, "R6 stall hold", int'(smp), int'(hold_d));
      end
      en = 1'b1; inc_v = 1'b0;
    end

    // R2: zero step gives a constant output
    do_reset();
    en = 1'b1; inc_d = 16'h0000; inc_v = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(smp == '0, "R2 zero step", int'(smp), 0);
    end

    // R4/R5/R6 random sweep with enable gaps and sparse step updates
    for (int i = 0; i < 4000; i++) begin
      en    = ($urandom % 8) != 0;
      inc_v = ($urandom % 4) == 0;
      inc_d = $urandom;
      @(negedge clk);
    end

    // R4: a step offered every cycle (linear sweep)
    for (int i = 0; i < 1000; i++) begin
      en = 1'b1; inc_v = 1'b1; inc_d = 16'(i * 37);
      @(negedge clk);
    end

    done = 1'b1;
    cmp_on = 1'b0;
    finish_run();
  end
endmodule